// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block takes one input clock and produces three clock-enable streams, one each for a CPU domain, a bus domain and a peripheral domain. A 16-bit control word selects the division ratio of each domain. Each domain has a 3-bit code field in the word, and the block turns that code into a ratio through a fixed table. Downstream logic stays on the input clock and advances only in cycles where its enable is high. Divide by 1 holds the enable high all the time.

Software loads the control word through a simple write strobe and data bus. The stored word is always visible on a readback port. Each write raises a one-cycle notify pulse. The block also reports the peripheral ratio that is currently in effect, so that timers and serial baud generators can rescale themselves.

A new ratio is not applied at once. Each divider picks up its new ratio only when it reaches its terminal count. An enable period in progress therefore always runs to its full old length.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset the stored control word is 0x0E0A. This gives CPU divide by 1, bus divide by 2 and peripheral divide by 4, and the block runs at these ratios with no write.
- R2: Bits 8:6 hold the CPU code. Codes 0, 1, 2, 3 and 4 give divide by 1, 2, 3, 4 and 5. Code 5 and above give divide by 8.
- R3: Bits 5:3 hold the bus code. The bus field uses the same code-to-ratio table as the CPU field.
- R4: Bits 2:0 hold the peripheral code. Codes 0, 1, 2 and 3 give divide by 2, 3, 4 and 6. Code 4 and above give divide by 8.
- R5: The reserved codes are 6 and 7 for CPU and bus, and 5, 6 and 7 for peripheral. Each reserved code acts as divide by 8.
- R6: At divide by 1 the enable of that domain stays high in every cycle.
- R7: At a ratio N greater than 1, the enable is high for exactly one input cycle out of every N cycles.
- R8: A written ratio takes effect only after the terminal count of the old period. The period in progress keeps its full old length, and the new period length applies from the next pulse on.
- R9: A write drives `rateNotify` high for exactly the one cycle after the write edge. In all other cycles `rateNotify` is low.
- R10: `ctrlWord` reads back all 16 bits of the last written value. Bits 15:9 have no effect on any ratio.
- R11: `perRatioNow` gives, as a binary number, the peripheral ratio that is currently in effect. It changes together with the peripheral divider's period switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from which all enables are derived |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to store |
| ctrlWord | output | 16 | Readback of the stored control word |
| cpuEn | output | 1 | CPU domain clock enable |
| busEn | output | 1 | Bus domain clock enable |
| perEn | output | 1 | Peripheral domain clock enable |
| perRatioNow | output | 4 | Peripheral ratio currently in effect |
| rateNotify | output | 1 | One-cycle pulse after each control write |

## Verification
The bench measures the spacing between enable pulses for every code in all three fields, reserved codes included. A wrong table entry or a missing divide-by-8 fallback shows up as a wrong period, and an enable that stays high for two cycles shows up as a period of 1. In one test the divider is running at divide by 8 and the bench writes a new ratio three cycles into the period. If the design applied the ratio at once, that period would be cut short and the status output would switch early. Writes with different upper bits catch a design that decodes bits 15:9 or fails to store them. Checks on the notify pulse in the cycle before a write, the cycle after it and the cycle after that catch a pulse that is missing, late or held too long.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int FIELD_W = 3;
  localparam int RATIO_W = 4;
  localparam int CPU_LSB = 6;
  localparam int BUS_LSB = 3;
  localparam int PER_LSB = 0;
  localparam int NUM_DOM = 3;

  typedef struct packed {
    logic [RATIO_W-1:0] cpuRatio;
    logic [RATIO_W-1:0] busRatio;
    logic [RATIO_W-1:0] perRatio;
    logic               notify;
  } ratio_strobe_t;

  // CPU and bus table; codes past the valid range fall back to 8.
  function automatic logic [RATIO_W-1:0] coreRatio(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0:    coreRatio = RATIO_W'(1);
      3'd1:    coreRatio = RATIO_W'(2);
      3'd2:    coreRatio = RATIO_W'(3);
      3'd3:    coreRatio = RATIO_W'(4);
      3'd4:    coreRatio = RATIO_W'(5);
      default: coreRatio = RATIO_W'(8);
    endcase
  endfunction

  // Peripheral table; codes past the valid range fall back to 8.
  function automatic logic [RATIO_W-1:0] periphRatio(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0:    periphRatio = RATIO_W'(2);
      3'd1:    periphRatio = RATIO_W'(3);
      3'd2:    periphRatio = RATIO_W'(4);
      3'd3:    periphRatio = RATIO_W'(6);
      default: periphRatio = RATIO_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int                CTRL_W     = 16,
  parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlWord,
  output ratio_strobe_t     strobe
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              notifyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= RESET_WORD;
      notifyQ <= 1'b0;
    end else begin
      notifyQ <= wrEn;
      if (wrEn) ctrlReg <= wrData;
    end
  end

  assign ctrlWord        = ctrlReg;
  assign strobe.cpuRatio = coreRatio(ctrlReg[CPU_LSB +: FIELD_W]);
  assign strobe.busRatio = coreRatio(ctrlReg[BUS_LSB +: FIELD_W]);
  assign strobe.perRatio = periphRatio(ctrlReg[PER_LSB +: FIELD_W]);
  assign strobe.notify   = notifyQ;

  assert_notify_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> strobe.notify);
  assert_notify_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !strobe.notify);
  assert_readback_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctrlWord == $past(wrData)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrlWord));
  assert_legal_core_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cpuRatio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8}) &&
    (strobe.busRatio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8}));
  assert_legal_per_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.perRatio inside {4'd2, 4'd3, 4'd4, 4'd6, 4'd8});
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int                 RATIO_W     = 4,
  parameter logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] nextRatio,
  output logic               enOut,
  output logic [RATIO_W-1:0] activeRatio
);
  logic [RATIO_W-1:0] cnt;
  logic               atTerm;

  assign atTerm = (cnt == activeRatio - RATIO_W'(1));
  assign enOut  = atTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt         <= '0;
      activeRatio <= RESET_RATIO;
    end else if (atTerm) begin
      cnt         <= '0;
      activeRatio <= nextRatio;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activeRatio);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    enOut |=> (enOut == (activeRatio == RATIO_W'(1))));
  assert_switch_at_term_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enOut |=> $stable(activeRatio));
  assert_div1_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio == RATIO_W'(1)) |-> enOut);
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
#(
  parameter int                CTRL_W     = 16,
  parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              cpuEn,
  output logic              busEn,
  output logic              perEn,
  output logic [RATIO_W-1:0] perRatioNow,
  output logic              rateNotify
);
  localparam logic [RATIO_W-1:0] CPU_RST = coreRatio(RESET_WORD[CPU_LSB +: FIELD_W]);
  localparam logic [RATIO_W-1:0] BUS_RST = coreRatio(RESET_WORD[BUS_LSB +: FIELD_W]);
  localparam logic [RATIO_W-1:0] PER_RST = periphRatio(RESET_WORD[PER_LSB +: FIELD_W]);
  localparam logic [NUM_DOM*RATIO_W-1:0] RST_PACK = {PER_RST, BUS_RST, CPU_RST};

  ratio_strobe_t              strobe;
  logic [NUM_DOM*RATIO_W-1:0] nextPack;
  logic [NUM_DOM*RATIO_W-1:0] activePack;
  logic [NUM_DOM-1:0]         enVec;

  clk_ratio_ctrl #(.CTRL_W(CTRL_W), .RESET_WORD(RESET_WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlWord(ctrlWord), .strobe(strobe)
  );

  assign nextPack = {strobe.perRatio, strobe.busRatio, strobe.cpuRatio};

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    clk_ratio_div #(
      .RATIO_W(RATIO_W),
      .RESET_RATIO(RST_PACK[g*RATIO_W +: RATIO_W])
    ) u_div (
      .clk(clk), .rstN(rstN),
      .nextRatio(nextPack[g*RATIO_W +: RATIO_W]),
      .enOut(enVec[g]),
      .activeRatio(activePack[g*RATIO_W +: RATIO_W])
    );
  end

  assign cpuEn       = enVec[0];
  assign busEn       = enVec[1];
  assign perEn       = enVec[2];
  assign perRatioNow = activePack[2*RATIO_W +: RATIO_W];
  assign rateNotify  = strobe.notify;

  assert_status_tracks_R11: assert property (@(posedge clk) disable iff (!rstN)
    !perEn |=> $stable(perRatioNow));
endmodule

// File: tb/clk_ratio_gen_tb.sv
module clk_ratio_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] ctrlWord;
  logic        cpuEn, busEn, perEn, rateNotify;
  logic [3:0]  perRatioNow;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  clk_ratio_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .ctrlWord(ctrlWord),
    .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn), .perRatioNow(perRatioNow),
    .rateNotify(rateNotify)
  );

  // word, cpu ratio, bus ratio, peripheral ratio
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0000, 4'd1, 4'd1, 4'd2},
    {16'h0049, 4'd2, 4'd2, 4'd3},
    {16'h00D3, 4'd4, 4'd3, 4'd6},
    {16'h0124, 4'd5, 4'd5, 4'd8},
    {16'h017D, 4'd8, 4'd8, 4'd8},
    {16'h01B6, 4'd8, 4'd8, 4'd8},
    {16'h01FF, 4'd8, 4'd8, 4'd8},
    {16'hFE0A, 4'd1, 4'd2, 4'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic domEn(input int sel);
    case (sel)
      0: domEn = cpuEn;
      1: domEn = busEn;
      default: domEn = perEn;
    endcase
  endfunction

  // Cycles from one enable pulse to the next, sampled at falling edges.
  task automatic measure(input int sel, output int period);
    int guard = 0;
    period = 0;
    while (!domEn(sel) && guard < 64) begin @(negedge clk); guard++; end
    do begin @(negedge clk); period++; end while (!domEn(sel) && period < 64);
  endtask

  task automatic writeWord(input logic [15:0] w);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset word", int'(ctrlWord), 16'h0E0A);
    check("R11 reset status", int'(perRatioNow), 4);
    check("R9 no notify after reset", int'(rateNotify), 0);
    measure(0, p); check("R1 R6 reset cpu period", p, 1);
    measure(1, p); check("R1 reset bus period", p, 2);
    measure(2, p); check("R1 reset per period", p, 4);
    // R6 divide by 1 stays high
    begin
      int lows = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (!cpuEn) lows++; end
      check("R6 cpu enable held high", lows, 0);
    end

    // Vector table: R2 R3 R4 R5 R7 R10 R11
    for (int v = 0; v < NV; v++) begin
      writeWord(VEC[v][27:12]);
      repeat (20) @(negedge clk);
      check("R10 readback", int'(ctrlWord), int'(VEC[v][27:12]));
      measure(0, p); check("R2 R5 R7 cpu period", p, int'(VEC[v][11:8]));
      measure(1, p); check("R3 R5 R7 bus period", p, int'(VEC[v][7:4]));
      measure(2, p); check("R4 R5 R7 per period", p, int'(VEC[v][3:0]));
      check("R11 status ratio", int'(perRatioNow), int'(VEC[v][3:0]));
    end

    // R9 notify pulse timing
    @(negedge clk);
    check("R9 quiet before write", int'(rateNotify), 0);
    wrEn = 1'b1; wrData = 16'h0E0C;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 pulse after write", int'(rateNotify), 1);
    @(negedge clk);
    check("R9 pulse one cycle", int'(rateNotify), 0);

    // R8 mid-period change must not shorten the running divide-by-8 period
    repeat (20) @(negedge clk);
    measure(2, p); check("R4 per at div 8", p, 8);
    begin
      int cnt = 0;
      repeat (2) begin @(negedge clk); cnt++; end
      writeWord(16'h0E08); cnt++;
      check("R11 status holds old ratio", int'(perRatioNow), 8);
      check("R10 readback new word", int'(ctrlWord), 16'h0E08);
      while (!perEn && cnt < 64) begin @(negedge clk); cnt++; end
      check("R8 period not shortened", cnt, 8);
      @(negedge clk);
      check("R8 R11 status after terminal", int'(perRatioNow), 2);
    end
    measure(2, p); check("R8 new period applied", p, 2);

    // R10 upper bits ignored: same low bits, different high bits
    writeWord(16'h5A08);
    repeat (10) @(negedge clk);
    check("R10 upper readback", int'(ctrlWord), 16'h5A08);
    measure(2, p); check("R10 upper bits no effect per", p, 2);
    measure(1, p); check("R10 upper bits no effect bus", p, 2);
    measure(0, p); check("R10 upper bits no effect cpu", p, 1);

    summary();
  end
endmodule